// File: doc/BRIEF.md
# Test Request Flag Controller

This block keeps a small set of sticky request flags that record events from three sources: one external pin and two internal event strobes. Software-visible sequencing happens through a test operation. A test strobe names one flag by index. The block returns that flag's value in the same cycle and clears the flag at the following clock edge. A processor core uses the result to decide whether to skip its next instruction.

Flag 0 latches timer/event-counter overflows. Flag 1 is shared by two sources. A source-select input decides which of them may set it: the serial transfer-complete strobe when the select is low, or a rising edge on the asynchronous request pin when the select is high. The pin goes through a two-flop synchronizer and an edge detector before it can set the flag. When a set and a test-clear hit the same flag in the same cycle, the set wins, so no event is lost.

Top module: `tstreq_ctrl`

## Requirements
- R1: After synchronous reset, both flags read 0 when tested.
- R2: A one-cycle high on `tmr_ovf_i` sets flag 0 (index 0) at the next clock edge. Flag 0 is never set by any other input.
- R3: With `src_sel_i` = 0, a high on `ser_done_i` sets flag 1 (index 1) at the next edge, and the request pin has no effect on flag 1.
- R4: With `src_sel_i` = 1, a rising edge on `ext_req_i` sets flag 1, and `ser_done_i` has no effect on flag 1.
- R5: The pin is edge-detected. Holding `ext_req_i` high sets flag 1 only once, and after that flag is cleared it stays 0 while the pin stays high.
- R6: `test_hit_o` equals the addressed flag's value from before the clear while `test_stb_i` is high, and is 0 while `test_stb_i` is low.
- R7: A test clears only the addressed flag at the next edge. The other flag keeps its value.
- R8: If a set event and a test-clear reach the same flag in one cycle, the flag is 1 after the edge.
- R9: A pin level that rises before clock edge k sets flag 1 at edge k+2. A test in the cycle after edge k+1 still reads 0, and a test after edge k+2 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_ovf_i | input | 1 | Timer overflow strobe, one cycle per event |
| ext_req_i | input | 1 | Asynchronous external request level |
| ser_done_i | input | 1 | Serial transfer-complete strobe |
| src_sel_i | input | 1 | Shared flag source: 0 = serial, 1 = pin |
| test_stb_i | input | 1 | Test-and-clear strobe |
| test_idx_i | input | 1 | Flag index under test: 0 = timer, 1 = shared |
| test_hit_o | output | 1 | Value of the tested flag before clearing |

## Verification
The checker assumes that `tmr_ovf_i`, `ser_done_i`, `src_sel_i`, `test_stb_i` and `test_idx_i` are synchronous to `clk` and stable around its rising edge. It also assumes `ext_req_i` is the only asynchronous input, and that a rise of flag 1 is attributed to the source selected in the preceding cycle. The bench drives every input just after the falling edge, so all of them are settled well before the next rising edge. It changes `ext_req_i` only rarely in the random phase, so that pin edges stay separable. Sampling of `test_hit_o` happens mid-cycle, against a cycle model that also includes the synchronizer delay.

// File: rtl/tstreq_pkg.sv
package tstreq_pkg;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_W    = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

    typedef enum logic [FLAG_W-1:0] {
        FLG_TIMER  = 1'b0,
        FLG_SHARED = 1'b1
    } flag_id_e;

    typedef enum logic {
        SRC_SERIAL = 1'b0,
        SRC_PIN    = 1'b1
    } shared_src_e;

    typedef struct packed {
        logic tmr_ovf;
        logic pin_rise;
        logic ser_done;
    } event_t;

    // Route raw events onto per-flag set requests.
    function automatic logic [NUM_FLAGS-1:0] route_sets(event_t ev, shared_src_e sel);
        logic [NUM_FLAGS-1:0] s;
        s             = '0;
        s[FLG_TIMER]  = ev.tmr_ovf;
        s[FLG_SHARED] = (sel == SRC_PIN) ? ev.pin_rise : ev.ser_done;
        return s;
    endfunction

endpackage

// File: rtl/tstreq_edge.sv
module tstreq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    // Synchronizer chain plus one history flop for edge detection.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_i;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/tstreq_flag.sv
module tstreq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Set dominates clear so a coincident event is kept.
    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= set_i | (q_o & ~clr_i);
    end
endmodule

// File: rtl/tstreq_ctrl.sv
module tstreq_ctrl
    import tstreq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_ovf_i,
    input  logic              ext_req_i,
    input  logic              ser_done_i,
    input  logic              src_sel_i,
    input  logic              test_stb_i,
    input  logic [FLAG_W-1:0] test_idx_i,
    output logic              test_hit_o
);
    logic                 pin_rise;
    event_t               ev;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_q;

    tstreq_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_req_i),
        .rise_o  (pin_rise)
    );

    always_comb begin
        ev.tmr_ovf  = tmr_ovf_i;
        ev.pin_rise = pin_rise;
        ev.ser_done = ser_done_i;
        set_vec     = route_sets(ev, shared_src_e'(src_sel_i));
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        assign clr_vec[g] = test_stb_i && (test_idx_i == FLAG_W'(g));
        tstreq_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_vec[g]),
            .clr_i (clr_vec[g]),
            .q_o   (flag_q[g])
        );
    end

    assign test_hit_o = test_stb_i & flag_q[test_idx_i];
endmodule

// File: rtl/tstreq_chk.sv
module tstreq_chk
    import tstreq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 tmr_ovf_i,
    input logic                 ser_done_i,
    input logic                 src_sel_i,
    input logic                 test_stb_i,
    input logic [FLAG_W-1:0]    test_idx_i,
    input logic                 test_hit_o,
    input logic                 pin_rise,
    input logic [NUM_FLAGS-1:0] flag_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> flag_q == '0); // R1
    AST_TMR_SET: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf_i |=> flag_q[0]); // R2
    AST_TMR_NO_SPONT: assert property (@(posedge clk) disable iff (rst)
        (!flag_q[0] && !tmr_ovf_i) |=> !flag_q[0]); // R2
    AST_SER_SET: assert property (@(posedge clk) disable iff (rst)
        (ser_done_i && !src_sel_i) |=> flag_q[1]); // R3
    AST_SER_ONLY_SRC: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag_q[1]) && !$past(src_sel_i)) |-> $past(ser_done_i)); // R3
    AST_PIN_ONLY_SRC: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag_q[1]) && $past(src_sel_i)) |-> $past(pin_rise)); // R4
    AST_HIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !test_stb_i |-> !test_hit_o); // R6
    AST_CLEAR_TMR: assert property (@(posedge clk) disable iff (rst)
        (test_stb_i && test_idx_i == 1'b0 && !tmr_ovf_i) |=> !flag_q[0]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (test_stb_i && test_idx_i == 1'b0 && tmr_ovf_i) |=> flag_q[0]); // R8
endmodule

bind tstreq_ctrl tstreq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tmr_ovf_i  (tmr_ovf_i),
    .ser_done_i (ser_done_i),
    .src_sel_i  (src_sel_i),
    .test_stb_i (test_stb_i),
    .test_idx_i (test_idx_i),
    .test_hit_o (test_hit_o),
    .pin_rise   (pin_rise),
    .flag_q     (flag_q)
);

// File: tb/tb_tstreq_ctrl.sv
module tb_tstreq_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tmr_ovf_i = 0, ext_req_i = 0, ser_done_i = 0, src_sel_i = 0;
    logic test_stb_i = 0;
    logic [0:0] test_idx_i = 0;
    logic test_hit_o;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // Reference state: flags and pin history (two sync stages + history).
    logic [1:0] m_flag;
    logic m_s1, m_s2, m_s3;

    always #5 clk = ~clk;

    tstreq_ctrl dut (
        .clk(clk), .rst(rst), .tmr_ovf_i(tmr_ovf_i), .ext_req_i(ext_req_i),
        .ser_done_i(ser_done_i), .src_sel_i(src_sel_i), .test_stb_i(test_stb_i),
        .test_idx_i(test_idx_i), .test_hit_o(test_hit_o)
    );

    function automatic logic exp_hit(logic stb, logic idx, logic [1:0] fl);
        return stb ? fl[idx] : 1'b0;
    endfunction

    function automatic logic [1:0] next_flags(logic [1:0] fl, logic tmr, logic rise,
                                              logic ser, logic sel, logic stb, logic idx);
        logic [1:0] s, c;
        s[0] = tmr;
        s[1] = sel ? rise : ser;
        c[0] = stb && (idx == 1'b0);
        c[1] = stb && (idx == 1'b1);
        return s | (fl & ~c);
    endfunction

    task automatic check(logic act, logic exp, string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: test_hit_o=%0b expected %0b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One cycle: drive after negedge, check mid-cycle, advance model at posedge.
    task automatic step(logic tmr, logic ext, logic ser, logic sel,
                        logic stb, logic idx, string tag);
        @(negedge clk);
        tmr_ovf_i = tmr; ext_req_i = ext; ser_done_i = ser;
        src_sel_i = sel; test_stb_i = stb; test_idx_i = idx;
        #1;
        check(test_hit_o, exp_hit(stb, idx, m_flag), tag);
        m_flag = next_flags(m_flag, tmr, m_s2 & ~m_s3, ser, sel, stb, idx);
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext;
        @(posedge clk);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog: run hung, expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int seed;
        logic ext_lvl;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        m_flag = 2'b00; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        step(0,0,0,0,1,0,"R1");
        step(0,0,0,0,1,1,"R1");

        // R2: timer overflow sets flag 0
        step(1,0,0,0,0,0,"R2");
        step(0,0,0,0,1,0,"R2");
        // R6: read-then-clear, and idle output is zero
        step(0,0,0,0,1,0,"R6");
        step(0,0,0,0,0,0,"R6");

        // R3: serial source selected, pin ignored
        step(0,0,1,0,0,0,"R3");
        step(0,0,0,0,1,1,"R3");
        step(0,1,0,0,0,0,"R3");
        step(0,1,0,0,0,0,"R3");
        step(0,1,0,0,0,0,"R3");
        step(0,1,0,0,1,1,"R3");
        step(0,0,0,0,0,0,"R3");
        step(0,0,0,0,0,0,"R3");
        step(0,0,0,0,0,0,"R3");

        // R4: pin source selected, serial ignored
        step(0,0,1,1,0,0,"R4");
        step(0,0,0,1,1,1,"R4");
        // R9: latency of the pin path; R8 via test in the setting cycle
        step(0,1,0,1,0,0,"R9");
        step(0,1,0,1,0,0,"R9");
        step(0,1,0,1,1,1,"R9");
        step(0,1,0,1,1,1,"R9");
        // R5: held pin does not re-set after clear
        step(0,1,0,1,1,1,"R5");
        step(0,1,0,1,0,0,"R5");
        step(0,1,0,1,1,1,"R5");
        step(0,0,0,1,0,0,"R5");
        step(0,0,0,1,0,0,"R5");
        step(0,0,0,1,0,0,"R5");

        // R7: clear one flag, other intact
        step(1,0,1,0,0,0,"R7");
        step(0,0,0,0,1,0,"R7");
        step(0,0,0,0,1,0,"R7");
        step(0,0,0,0,1,1,"R7");
        step(0,0,0,0,1,1,"R7");

        // R8: set and clear together
        step(1,0,0,0,0,0,"R8");
        step(1,0,0,0,1,0,"R8");
        step(0,0,0,0,1,0,"R8");
        step(0,0,0,0,1,0,"R8");

        // Random phase: slow pin, random strobes
        ext_lvl = 0;
        for (int i = 0; i < 3000; i++) begin
            logic sel;
            if (($urandom() % 8) == 0) ext_lvl = ~ext_lvl;
            sel = (($urandom() % 64) == 0) ? 1'b0 : src_sel_i;
            if (($urandom() % 64) == 1) sel = 1'b1;
            step(($urandom() % 5) == 0, ext_lvl, ($urandom() % 6) == 0, sel,
                 ($urandom() % 3) == 0, 1'($urandom()), "R6");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule